// File: doc/BRIEF.md
# Two-Level Coherence Write Tracker

This block sits beside a second-level cache whose contents include everything held in the first-level cache above it. For a small, directly indexed set of lines it keeps the MESI state of each line at both levels. On every processor write that hits a tracked line, it moves the two states one step along a fixed sequence. It drives the first-level writeback/writethrough select so that the first-level copy becomes dirty one write after the second-level copy does. While the first-level copy is still clean, an external snoop only needs to look at the second level.

External inquire (snoop) cycles are answered with a hit indication, plus a modified-hit indication once the second-level copy is dirty. A modified hit also starts a follow-on inquire to the first level through a request/acknowledge pair. Processor writes are stalled for as long as that inquire is running. A mode input lets the second level go straight from shared to modified, which removes one step from the write sequence. Data storage, tag compare and bus arbitration live elsewhere. A `line_fill` pulse marks a line as shared at both levels.

Top module: `coh_write_tracker`

## Requirements
- R1: With `direct_modify` low, the first write to a line that is shared at both levels gives a one-cycle pulse on `wt_mem`, `inv_others` and `l2_wr` in the cycle after the write is accepted, with `l1_wb` low (0 = writethrough). The line becomes shared in L1 and exclusive in L2.
- R2: With `direct_modify` low, the next write to that line pulses `l2_wr` with `l1_wb` high (1 = writeback) and leaves `wt_mem` and `inv_others` low. The line becomes exclusive in L1 and modified in L2.
- R3: With `direct_modify` high, the first write to a line shared at both levels pulses `wt_mem`, `inv_others`, `l2_wr` and `l1_wb` together. The line goes straight to exclusive in L1 and modified in L2.
- R4: A write to a line that is exclusive in L1 and modified in L2 makes L1 modified, and that write and every later write produce no pulse on any of the four write outputs.
- R5: An inquire to a valid line whose L2 copy is not modified gives `inq_hit` high and `inq_hitm` low in the next cycle. `l1_inq_req` and `l2_busy` stay low.
- R6: An inquire to a line whose L2 copy is modified gives both `inq_hit` and `inq_hitm` in the next cycle and raises `l1_inq_req`.
- R7: `l1_inq_req` and `l2_busy` stay high until the cycle after `l1_inq_ack` is seen. `wr_ready` is low throughout that window.
- R8: An inquire with `inq_inv` high leaves the line invalid at both levels, after the first-level inquire if one was needed. A later write to it produces no pulses, and a later inquire gets no hit.
- R9: An inquire with `inq_inv` low leaves the line shared at both levels, so the next write behaves as the first write of R1 or R3.
- R10: After reset every line is invalid, all outputs except `wr_ready` are low, and `wr_ready` is high.
- R11: A write to an invalid line is accepted, produces no pulses and changes no state.
- R12: When `inq_valid` and `wr_valid` name the same line in one cycle, `wr_ready` is low. `wr_ready` stays high when they name different lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| direct_modify | input | 1 | 1: L2 goes shared to modified on the first write |
| line_fill | input | 1 | Mark `fill_idx` shared at both levels |
| fill_idx | input | IDX_W | Line index for the fill |
| wr_valid | input | 1 | Processor write hitting a tracked line |
| wr_idx | input | IDX_W | Line index of the write |
| wr_ready | output | 1 | Write accepted this cycle when high |
| l1_wb | output | 1 | L1 writeback (1) / writethrough (0) select |
| wt_mem | output | 1 | Write goes through to memory |
| inv_others | output | 1 | Invalidate the line in other caching masters |
| l2_wr | output | 1 | Write updates the L2 copy |
| inq_valid | input | 1 | External inquire cycle |
| inq_idx | input | IDX_W | Line index of the inquire |
| inq_inv | input | 1 | Inquire invalidates the line |
| inq_hit | output | 1 | Inquire hit a valid line |
| inq_hitm | output | 1 | Inquire hit a modified L2 line |
| l1_inq_req | output | 1 | Follow-on inquire to L1 requested |
| l1_inq_ack | input | 1 | L1 inquire finished |
| l2_busy | output | 1 | Processor L2 accesses blocked |

## Verification
Every line is filled and then written zero to four times in both modes. Each run ends with a plain or an invalidating inquire. The run length shows which stage of the sequence drives each write pulse pattern and where the modified hit starts, and the two modes tell the shortened sequence from the full one. After each inquire, one more write and one more inquire show whether the line ended shared or invalid. The modified-hit runs also try a write while the first-level inquire is open, to check the stall. Separate patterns cover a write to a line never filled and a write that collides with an inquire to the same line.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef struct packed {
    mesi_t l1;
    mesi_t l2;
    logic  wt_mem;
    logic  inv;
    logic  l2_wr;
    logic  wb;
  } wr_step_t;

  // One step of the write sequence for a line at (l1, l2).
  function automatic wr_step_t write_step(mesi_t l1, mesi_t l2, logic direct);
    wr_step_t r;
    r.l1     = l1;
    r.l2     = l2;
    r.wt_mem = 1'b0;
    r.inv    = 1'b0;
    r.l2_wr  = 1'b0;
    r.wb     = 1'b0;
    if (l1 == ST_S && l2 == ST_S) begin
      r.wt_mem = 1'b1;
      r.inv    = 1'b1;
      r.l2_wr  = 1'b1;
      if (direct) begin
        r.l2 = ST_M;
        r.l1 = ST_E;
        r.wb = 1'b1;
      end else begin
        r.l2 = ST_E;
      end
    end else if (l1 == ST_S && l2 == ST_E) begin
      r.l2    = ST_M;
      r.l1    = ST_E;
      r.wb    = 1'b1;
      r.l2_wr = 1'b1;
    end else if (l1 == ST_E && l2 == ST_M) begin
      r.l1 = ST_M;
    end
    return r;
  endfunction

  // State both levels take once an inquire completes.
  function automatic mesi_t snoop_state(logic inv);
    return inv ? ST_I : ST_S;
  endfunction

endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] wr_rd_idx,
  output mesi_t            wr_rd_l1,
  output mesi_t            wr_rd_l2,
  input  logic [IDX_W-1:0] sn_rd_idx,
  output mesi_t            sn_rd_l2,
  input  logic             wr_upd_en,
  input  logic [IDX_W-1:0] wr_upd_idx,
  input  mesi_t            wr_upd_l1,
  input  mesi_t            wr_upd_l2,
  input  logic             sn_upd_en,
  input  logic [IDX_W-1:0] sn_upd_idx,
  input  mesi_t            sn_upd_state,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx
);

  mesi_t l1_arr [NUM_LINES];
  mesi_t l2_arr [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    mesi_t l1_r, l2_r;
    logic  sn_hit, wr_hit, fl_hit;
    assign sn_hit = sn_upd_en && (sn_upd_idx == IDX_W'(g));
    assign wr_hit = wr_upd_en && (wr_upd_idx == IDX_W'(g));
    assign fl_hit = fill_en   && (fill_idx   == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        l1_r <= ST_I;
        l2_r <= ST_I;
      end else if (sn_hit) begin
        l1_r <= sn_upd_state;
        l2_r <= sn_upd_state;
      end else if (wr_hit) begin
        l1_r <= wr_upd_l1;
        l2_r <= wr_upd_l2;
      end else if (fl_hit) begin
        l1_r <= ST_S;
        l2_r <= ST_S;
      end
    end

    assign l1_arr[g] = l1_r;
    assign l2_arr[g] = l2_r;
  end

  assign wr_rd_l1 = l1_arr[wr_rd_idx];
  assign wr_rd_l2 = l2_arr[wr_rd_idx];
  assign sn_rd_l2 = l2_arr[sn_rd_idx];

  // R12: write and snoop never update the same line in one cycle
  single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_upd_en && sn_upd_en) |-> (wr_upd_idx != sn_upd_idx));

endmodule

// File: rtl/coh_write_seq.sv
module coh_write_seq
  import coh_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_fire,
  input  logic  direct,
  input  mesi_t cur_l1,
  input  mesi_t cur_l2,
  output logic  upd_en,
  output mesi_t nxt_l1,
  output mesi_t nxt_l2,
  output logic  l1_wb,
  output logic  wt_mem,
  output logic  inv_others,
  output logic  l2_wr
);

  wr_step_t step;
  assign step   = write_step(cur_l1, cur_l2, direct);
  assign upd_en = wr_fire;
  assign nxt_l1 = step.l1;
  assign nxt_l2 = step.l2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1_wb      <= 1'b0;
      wt_mem     <= 1'b0;
      inv_others <= 1'b0;
      l2_wr      <= 1'b0;
    end else begin
      l1_wb      <= wr_fire & step.wb;
      wt_mem     <= wr_fire & step.wt_mem;
      inv_others <= wr_fire & step.inv;
      l2_wr      <= wr_fire & step.l2_wr;
    end
  end

  // R1
  memory_wt_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wt_mem |-> (inv_others && l2_wr));

  // R2
  wb_only_with_l2_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_wb |-> l2_wr);

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inq_valid,
  input  logic [IDX_W-1:0] inq_idx,
  input  logic             inq_inv,
  input  logic             l1_inq_ack,
  input  mesi_t            cur_l2,
  output logic [IDX_W-1:0] rd_idx,
  output logic             upd_en,
  output logic [IDX_W-1:0] upd_idx,
  output mesi_t            upd_state,
  output logic             inq_hit,
  output logic             inq_hitm,
  output logic             l1_inq_req,
  output logic             l2_busy
);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             inv_q;

  logic take, line_hit, line_mod, ack_done;
  assign take     = inq_valid & ~busy_q;
  assign line_hit = take & (cur_l2 != ST_I);
  assign line_mod = line_hit & (cur_l2 == ST_M);
  assign ack_done = busy_q & l1_inq_ack;

  assign rd_idx    = busy_q ? idx_q : inq_idx;
  assign upd_idx   = busy_q ? idx_q : inq_idx;
  assign upd_en    = (line_hit & ~line_mod) | ack_done;
  assign upd_state = snoop_state(busy_q ? inv_q : inq_inv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      inv_q    <= 1'b0;
      inq_hit  <= 1'b0;
      inq_hitm <= 1'b0;
    end else begin
      inq_hit  <= line_hit;
      inq_hitm <= line_mod;
      if (line_mod) begin
        busy_q <= 1'b1;
        idx_q  <= inq_idx;
        inv_q  <= inq_inv;
      end else if (ack_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign l1_inq_req = busy_q;
  assign l2_busy    = busy_q;

  // R6
  busy_starts_with_hitm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l2_busy) |-> inq_hitm);

  // R7
  busy_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_busy && !l1_inq_ack) |=> l2_busy);

  // R5
  plain_hit_no_l1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inq_hit && !inq_hitm) |-> !l1_inq_req);

  // R6
  hitm_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inq_hitm |-> inq_hit);

endmodule

// File: rtl/coh_write_tracker.sv
module coh_write_tracker
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             direct_modify,
  input  logic             line_fill,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             wr_ready,
  output logic             l1_wb,
  output logic             wt_mem,
  output logic             inv_others,
  output logic             l2_wr,
  input  logic             inq_valid,
  input  logic [IDX_W-1:0] inq_idx,
  input  logic             inq_inv,
  output logic             inq_hit,
  output logic             inq_hitm,
  output logic             l1_inq_req,
  input  logic             l1_inq_ack,
  output logic             l2_busy
);

  mesi_t            wr_l1, wr_l2, sn_l2;
  mesi_t            wr_nxt_l1, wr_nxt_l2, sn_state;
  logic             wr_fire, wr_upd, sn_upd;
  logic [IDX_W-1:0] sn_rd_idx, sn_upd_idx;

  // Writes wait while the L1 inquire runs, or when they collide with a new inquire.
  assign wr_ready = ~l2_busy & ~(inq_valid && (inq_idx == wr_idx));
  assign wr_fire  = wr_valid & wr_ready;

  coh_line_table #(.NUM_LINES(NUM_LINES)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_rd_idx    (wr_idx),
    .wr_rd_l1     (wr_l1),
    .wr_rd_l2     (wr_l2),
    .sn_rd_idx    (sn_rd_idx),
    .sn_rd_l2     (sn_l2),
    .wr_upd_en    (wr_upd),
    .wr_upd_idx   (wr_idx),
    .wr_upd_l1    (wr_nxt_l1),
    .wr_upd_l2    (wr_nxt_l2),
    .sn_upd_en    (sn_upd),
    .sn_upd_idx   (sn_upd_idx),
    .sn_upd_state (sn_state),
    .fill_en      (line_fill),
    .fill_idx     (fill_idx)
  );

  coh_write_seq u_wseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .direct     (direct_modify),
    .cur_l1     (wr_l1),
    .cur_l2     (wr_l2),
    .upd_en     (wr_upd),
    .nxt_l1     (wr_nxt_l1),
    .nxt_l2     (wr_nxt_l2),
    .l1_wb      (l1_wb),
    .wt_mem     (wt_mem),
    .inv_others (inv_others),
    .l2_wr      (l2_wr)
  );

  coh_snoop_ctrl #(.IDX_W(IDX_W)) u_snoop (
    .clk        (clk),
    .rst_n      (rst_n),
    .inq_valid  (inq_valid),
    .inq_idx    (inq_idx),
    .inq_inv    (inq_inv),
    .l1_inq_ack (l1_inq_ack),
    .cur_l2     (sn_l2),
    .rd_idx     (sn_rd_idx),
    .upd_en     (sn_upd),
    .upd_idx    (sn_upd_idx),
    .upd_state  (sn_state),
    .inq_hit    (inq_hit),
    .inq_hitm   (inq_hitm),
    .l1_inq_req (l1_inq_req),
    .l2_busy    (l2_busy)
  );

  // R7
  no_write_pulse_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(l2_busy) && l2_busy) |-> !l2_wr);

endmodule

// File: tb/coh_write_tracker_test.sv
module coh_write_tracker_test;

  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       direct_modify = 1'b0;
  logic       line_fill = 1'b0;
  logic [1:0] fill_idx = '0;
  logic       wr_valid = 1'b0;
  logic [1:0] wr_idx = '0;
  logic       wr_ready;
  logic       l1_wb, wt_mem, inv_others, l2_wr;
  logic       inq_valid = 1'b0;
  logic [1:0] inq_idx = '0;
  logic       inq_inv = 1'b0;
  logic       inq_hit, inq_hitm, l1_inq_req;
  logic       l1_inq_ack = 1'b0;
  logic       l2_busy;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  coh_write_tracker #(.NUM_LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .direct_modify(direct_modify),
    .line_fill(line_fill), .fill_idx(fill_idx),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_ready(wr_ready),
    .l1_wb(l1_wb), .wt_mem(wt_mem), .inv_others(inv_others), .l2_wr(l2_wr),
    .inq_valid(inq_valid), .inq_idx(inq_idx), .inq_inv(inq_inv),
    .inq_hit(inq_hit), .inq_hitm(inq_hitm), .l1_inq_req(l1_inq_req),
    .l1_inq_ack(l1_inq_ack), .l2_busy(l2_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Stage: 0 = S/S, 1 = S/E, 2 = E/M, 3 = M/M (L1/L2).
  function automatic int next_stage(int s, int d);
    if (s == 0) return (d != 0) ? 2 : 1;
    return (s >= 3) ? 3 : s + 1;
  endfunction

  // Expected {l1_wb, wt_mem, inv_others, l2_wr} for a write taken at stage s.
  function automatic int wr_pulses(int s, int d);
    if (s == 0) return (d != 0) ? 4'b1111 : 4'b0111;
    if (s == 1) return 4'b1001;
    return 0;
  endfunction

  function automatic string stage_tag(int s, int d);
    if (s == 0) return (d != 0) ? "R3" : "R1";
    if (s == 1) return "R2";
    return (d != 0 && s == 2) ? "R3/R4" : "R4";
  endfunction

  task automatic do_fill(input int idx);
    @(negedge clk);
    line_fill = 1'b1;
    fill_idx  = 2'(idx);
    @(negedge clk);
    line_fill = 1'b0;
  endtask

  task automatic do_write(input int idx, input int exp, input string tag);
    @(negedge clk);
    wr_idx   = 2'(idx);
    wr_valid = 1'b1;
    #1 chk({tag, " wr_ready"}, wr_ready, 1);
    @(negedge clk);
    wr_valid = 1'b0;
    chk({tag, " write pulses"}, {l1_wb, wt_mem, inv_others, l2_wr}, exp);
  endtask

  task automatic do_inq(input int idx, input int inv, input int exp_hit,
                        input int exp_hitm, input string tag);
    int m;
    m = (exp_hitm != 0) ? 1 : 0;
    @(negedge clk);
    inq_idx   = 2'(idx);
    inq_inv   = inv[0];
    inq_valid = 1'b1;
    @(negedge clk);
    inq_valid = 1'b0;
    chk({tag, " inquire response"}, {inq_hit, inq_hitm, l1_inq_req, l2_busy},
        {exp_hit[0], m[0], m[0], m[0]});
    if (l1_inq_req) begin
      repeat (2) @(negedge clk);
      chk("R7 busy held before ack", {inq_hit, l1_inq_req, l2_busy}, 3'b011);
      wr_idx   = 2'((idx + 1) % N);
      wr_valid = 1'b1;
      #1 chk("R7 write stalled", wr_ready, 0);
      wr_valid = 1'b0;
      @(negedge clk);
      l1_inq_ack = 1'b1;
      @(negedge clk);
      l1_inq_ack = 1'b0;
      chk("R7 released after ack", {l1_inq_req, l2_busy}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk("R10 outputs after reset",
        {l1_wb, wt_mem, inv_others, l2_wr, inq_hit, inq_hitm, l1_inq_req, l2_busy}, 0);
    chk("R10 wr_ready after reset", wr_ready, 1);
    for (int i = 0; i < N; i++) do_inq(i, 0, 0, 0, "R10");
    // R11
    do_write(1, 0, "R11");
    do_inq(1, 0, 0, 0, "R11");
    // R12
    @(negedge clk);
    wr_idx = 2'd2; wr_valid = 1'b1;
    inq_idx = 2'd2; inq_valid = 1'b1; inq_inv = 1'b0;
    #1 chk("R12 same line collision", wr_ready, 0);
    inq_idx = 2'd3;
    #1 chk("R12 different lines", wr_ready, 1);
    wr_valid = 1'b0; inq_valid = 1'b0;

    for (int d = 0; d < 2; d++) begin
      @(negedge clk);
      direct_modify = d[0];
      for (int n = 0; n < 5; n++) begin
        for (int inv = 0; inv < 2; inv++) begin
          for (int idx = 0; idx < N; idx++) begin
            int s;
            s = 0;
            do_fill(idx);
            for (int k = 0; k < n; k++) begin
              do_write(idx, wr_pulses(s, d), stage_tag(s, d));
              s = next_stage(s, d);
            end
            do_inq(idx, inv, 1, (s >= 2) ? 1 : 0, (s >= 2) ? "R6" : "R5");
            if (inv != 0) begin
              do_write(idx, 0, "R8");
              do_inq(idx, 0, 0, 0, "R8");
            end else begin
              do_write(idx, wr_pulses(0, d), "R9");
              do_inq(idx, 1, 1, (next_stage(0, d) >= 2) ? 1 : 0, "R9");
            end
          end
        end
      end
    end

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule